// File: doc/BRIEF.md
# Watchdog Status and Error Flags

This block keeps the status word of a watchdog timer together with the 16-bit timer count behind it. Every cycle it presents a 32-bit read-only word. The upper half carries the live count. The low byte carries six flags: access error, overflow error, clock select, disable, time-out mode and prewarning. The flags are set by event strobes and cleared by fixed rules. After a reset caused by the watchdog itself, the two error flags keep their values, so that software can see why the reset happened.

The password check and the reset generator sit outside the block. Illegal accesses arrive as strobes. A legal write to the control register arrives as a valid-modify strobe that carries the end-of-init bit, disable and clock-select values and a reload value. When the count wraps, the block enters prewarning and counts down a fixed number of clocks. It then raises a one-cycle request that the reset generator turns into a watchdog reset. That reset comes back to this block as the synchronous reset, with cause code 11.

Top module: `wdt_status`

## Requirements
- R1: The status word is {count[15:0], 10'b0, prewarn(bit5), timeout_mode(bit4), disable(bit3), clksel(bit2), overflow_err(bit1), access_err(bit0)}. Bits 15:6 always read 0.
- R2: After the asynchronous reset, or after a synchronous reset with cause code 00 (power-on), 01 (hardware) or 10 (software), the status word is 0xFFFC0010.
- R3: After a synchronous reset with cause code 11 (watchdog), bits 1:0 keep their previous values. The remaining bits take their reset values (count 0xFFFC, time-out mode 1, all others 0).
- R4: A pulse on the illegal-password or the illegal-modify strobe sets the access error flag on the next clock edge.
- R5: A valid modify with end-of-init 1 clears both error flags while prewarning is 0. If a set and this clear occur in the same cycle, the set wins.
- R6: While prewarning is 1, no valid modify clears either error flag or the time-out mode flag.
- R7: A tick raises the count by one only when disable is 0 and prewarning is 0. A valid modify with end-of-init 1 loads the count from the reload input, even during prewarning. A valid modify with end-of-init 1 outside prewarning also clears time-out mode.
- R8: A counting tick at 0xFFFF wraps the count to 0x0000 and sets prewarning. If time-out mode is 1 at that moment, the same tick also sets the overflow error flag.
- R9: The watchdog reset request is high for exactly one cycle, PW_CYCLES clocks after prewarning rises. It fires only once per prewarning phase.
- R10: Any valid modify copies the disable and clock-select inputs into bits 3 and 2. A valid modify with end-of-init 0 sets time-out mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| srst_i | input | 1 | Synchronous reset, applied with a cause code |
| rst_cause_i | input | 2 | Reset cause: 00 power-on, 01 hardware, 10 software, 11 watchdog |
| pw_err_i | input | 1 | Illegal password access strobe |
| mod_err_i | input | 1 | Illegal modify access strobe |
| mod_valid_i | input | 1 | Valid modify access strobe |
| mod_endinit_i | input | 1 | End-of-init value written with the valid modify |
| mod_disable_i | input | 1 | Disable value written with the valid modify |
| mod_clksel_i | input | 1 | Clock-select value written with the valid modify |
| reload_i | input | 16 | Count reload value |
| tick_i | input | 1 | Timer tick enable |
| status_o | output | 32 | Status word |
| wdt_rst_req_o | output | 1 | One-cycle watchdog reset request |

## Verification
The assertions check the following on every cycle: the zero bits, access-error setting, error retention during prewarning, prewarning stickiness, count stability without a tick or reload, retention of the error flags across a watchdog reset, and the single-cycle request that only occurs inside prewarning. The directed scenarios are the only place where exact values are shown. These cover the reset words for each cause code, the count after a reload and after ticks, whether the overflow error is set at a wrap, set-over-clear priority, the frozen count under disable, and the exact delay of the request.

// File: rtl/wdt_status_pkg.sv
package wdt_status_pkg;
  typedef enum logic [1:0] {
    CAUSE_POR = 2'b00,
    CAUSE_HW  = 2'b01,
    CAUSE_SW  = 2'b10,
    CAUSE_WDT = 2'b11
  } rst_cause_e;

  localparam int unsigned CNT_W     = 16;
  localparam logic [CNT_W-1:0] CNT_RST = 16'hFFFC;
  localparam int unsigned N_ERR     = 2;
  localparam int unsigned ERR_ACC   = 0;
  localparam int unsigned ERR_OVF   = 1;
endpackage

// File: rtl/wdt_err_flags.sv
module wdt_err_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic         keep_i,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q <= 1'b0;
      else if (srst_i)     q <= keep_i ? q : 1'b0;
      else if (set_i[g])   q <= 1'b1;   // set beats clear
      else if (clr_i)      q <= 1'b0;
    end
    assign flags_o[g] = q;
  end
endmodule

// File: rtl/wdt_mode_flags.sv
module wdt_mode_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic prewarn_i,
  input  logic mod_valid_i,
  input  logic mod_endinit_i,
  input  logic mod_disable_i,
  input  logic mod_clksel_i,
  output logic dis_o,
  output logic clksel_o,
  output logic tomode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_o    <= 1'b0;
      clksel_o <= 1'b0;
      tomode_o <= 1'b1;
    end else if (srst_i) begin
      dis_o    <= 1'b0;
      clksel_o <= 1'b0;
      tomode_o <= 1'b1;
    end else if (mod_valid_i) begin
      dis_o    <= mod_disable_i;
      clksel_o <= mod_clksel_i;
      if (!mod_endinit_i)  tomode_o <= 1'b1;
      else if (!prewarn_i) tomode_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int unsigned       W      = 16,
  parameter logic [W-1:0]      RST_V  = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  assign wrap_o = inc_i && !load_i && (cnt_o == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= RST_V;
    else if (srst_i)  cnt_o <= RST_V;
    else if (load_i)  cnt_o <= load_val_i;
    else if (inc_i)   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/wdt_prewarn.sv
module wdt_prewarn #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic wrap_i,
  output logic pw_o,
  output logic req_o
);
  localparam int unsigned CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          fired_q;
  logic          expire;

  assign expire = pw_o && (cnt_q == '0) && !fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pw_o    <= 1'b0;
      cnt_q   <= '0;
      fired_q <= 1'b0;
      req_o   <= 1'b0;
    end else if (srst_i) begin
      pw_o    <= 1'b0;
      cnt_q   <= '0;
      fired_q <= 1'b0;
      req_o   <= 1'b0;
    end else begin
      req_o <= expire;
      if (expire) fired_q <= 1'b1;
      if (!pw_o && wrap_i) begin
        pw_o  <= 1'b1;
        cnt_q <= LOAD;
      end else if (pw_o && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_status.sv
module wdt_status
  import wdt_status_pkg::*;
#(
  parameter int unsigned PW_CYCLES = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        srst_i,
  input  logic [1:0]  rst_cause_i,
  input  logic        pw_err_i,
  input  logic        mod_err_i,
  input  logic        mod_valid_i,
  input  logic        mod_endinit_i,
  input  logic        mod_disable_i,
  input  logic        mod_clksel_i,
  input  logic [15:0] reload_i,
  input  logic        tick_i,
  output logic [31:0] status_o,
  output logic        wdt_rst_req_o
);
  logic [CNT_W-1:0] cnt;
  logic [N_ERR-1:0] err, err_set;
  logic             wrap, pw, dis, clksel, tomode;
  logic             endinit_wr, err_clr, inc;

  assign endinit_wr = mod_valid_i && mod_endinit_i;
  assign err_clr    = endinit_wr && !pw;
  assign inc        = tick_i && !dis && !pw;

  assign err_set[ERR_ACC] = pw_err_i || mod_err_i;
  assign err_set[ERR_OVF] = wrap && tomode;

  wdt_timer #(.W(CNT_W), .RST_V(CNT_RST)) u_timer (
    .clk_i, .rst_ni, .srst_i,
    .load_i(endinit_wr), .load_val_i(reload_i), .inc_i(inc),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  wdt_prewarn #(.CYCLES(PW_CYCLES)) u_pw (
    .clk_i, .rst_ni, .srst_i,
    .wrap_i(wrap), .pw_o(pw), .req_o(wdt_rst_req_o)
  );

  wdt_err_flags #(.N(N_ERR)) u_err (
    .clk_i, .rst_ni, .srst_i,
    .keep_i(rst_cause_e'(rst_cause_i) == CAUSE_WDT),
    .set_i(err_set), .clr_i(err_clr), .flags_o(err)
  );

  wdt_mode_flags u_mode (
    .clk_i, .rst_ni, .srst_i,
    .prewarn_i(pw), .mod_valid_i, .mod_endinit_i,
    .mod_disable_i, .mod_clksel_i,
    .dis_o(dis), .clksel_o(clksel), .tomode_o(tomode)
  );

  assign status_o = {cnt, 10'b0, pw, tomode, dis, clksel, err[ERR_OVF], err[ERR_ACC]};
endmodule

// File: rtl/wdt_status_sva.sv
module wdt_status_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        srst_i,
  input logic [1:0]  rst_cause_i,
  input logic        pw_err_i,
  input logic        mod_err_i,
  input logic        mod_valid_i,
  input logic        mod_endinit_i,
  input logic        tick_i,
  input logic [31:0] status_o,
  input logic        wdt_rst_req_o
);
  a_r1_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[15:6] == 10'b0);

  a_r4_acc_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pw_err_i || mod_err_i) && !srst_i |=> status_o[0]);

  a_r6_pw_keeps_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[5] && !srst_i |=> status_o[1:0] == $past(status_o[1:0]) || status_o[1:0] > $past(status_o[1:0]));

  a_r8_pw_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[5] && !srst_i |=> status_o[5]);

  a_r7_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srst_i && !tick_i && !(mod_valid_i && mod_endinit_i) |=> $stable(status_o[31:16]));

  a_r3_wdt_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i && rst_cause_i == 2'b11 |=> status_o[1:0] == $past(status_o[1:0]) && status_o[3:2] == 2'b00);

  a_r9_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_req_o |=> !wdt_rst_req_o);

  a_r9_req_in_pw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_req_o |-> status_o[5]);
endmodule

bind wdt_status wdt_status_sva u_sva (.*);

// File: tb/tb_wdt_status.sv
module tb_wdt_status;
  localparam int unsigned PW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        srst = 1'b0;
  logic [1:0]  cause = 2'b00;
  logic        pw_err = 1'b0, mod_err = 1'b0;
  logic        mv = 1'b0, mei = 1'b0, mdis = 1'b0, mclk = 1'b0;
  logic [15:0] reload = '0;
  logic        tick = 1'b0;
  logic [31:0] status;
  logic        req;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  wdt_status #(.PW_CYCLES(PW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .rst_cause_i(cause),
    .pw_err_i(pw_err), .mod_err_i(mod_err), .mod_valid_i(mv),
    .mod_endinit_i(mei), .mod_disable_i(mdis), .mod_clksel_i(mclk),
    .reload_i(reload), .tick_i(tick), .status_o(status), .wdt_rst_req_o(req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs change just after negedge; the edge in between registers them
  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    srst = 0; pw_err = 0; mod_err = 0; mv = 0; mei = 0; tick = 0;
  endtask

  task automatic wr(input logic ei, input logic d, input logic c, input logic [15:0] rl);
    mv = 1; mei = ei; mdis = d; mclk = c; reload = rl;
    cyc(); idle();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; cyc(); end
    tick = 0;
  endtask

  task automatic sreset(input logic [1:0] c);
    srst = 1; cause = c; cyc(); idle();
  endtask

  task automatic t_reset();
    chk("R2 async reset word", status, 32'hFFFC0010);
    chk("R1 zero bits", {22'b0, status[15:6]}, 32'h0);
    chk("R9 no request after reset", {31'b0, req}, 32'h0);
  endtask

  task automatic t_count();
    ticks(2);
    chk("R7 ticks from reset", status, 32'hFFFE0010);
    wr(1, 0, 0, 16'h1234);
    chk("R7 reload clears timeout", status, 32'h12340000);
    ticks(3);
    chk("R7 counting", status, 32'h12370000);
  endtask

  task automatic t_access();
    pw_err = 1; cyc(); idle();
    chk("R4 password strobe", status, 32'h12370001);
    wr(1, 0, 0, 16'h1237);
    chk("R5 endinit clears", status, 32'h12370000);
    mod_err = 1; cyc(); idle();
    chk("R4 modify strobe", status, 32'h12370001);
    mod_err = 1; mv = 1; mei = 1; reload = 16'h1237; cyc(); idle();
    chk("R5 set wins over clear", status, 32'h12370001);
    wr(1, 0, 0, 16'h1237);
    chk("R5 clear alone", status, 32'h12370000);
  endtask

  task automatic t_mode();
    wr(0, 1, 1, 16'h0000);
    chk("R10 endinit0 write sets fields", status, 32'h1237001C);
    ticks(4);
    chk("R10 disable freezes count", status, 32'h1237001C);
    wr(1, 0, 0, 16'h0050);
    chk("R7 reload after disable", status, 32'h00500000);
  endtask

  task automatic t_overflow();
    int n;
    wr(1, 0, 0, 16'hFFFE);
    wr(0, 0, 0, 16'h0000);
    chk("R10 timeout mode back on", status, 32'hFFFE0010);
    ticks(1);
    chk("R8 before wrap", status, 32'hFFFF0010);
    ticks(1);
    chk("R8 wrap sets pw and overflow", status, 32'h00000032);
    n = 0;
    pw_err = 1; cyc(); idle(); n++;
    chk("R4 access error in pw", status, 32'h00000033);
    wr(1, 0, 0, 16'h0100); n++;
    chk("R6 pw blocks clear, reload applies", status, 32'h01000033);
    ticks(2); n += 2;
    chk("R7 count frozen in pw", status, 32'h01000033);
    while (!req && n < PW + 5) begin cyc(); n++; end
    chk("R9 request delay", n, PW);
    cyc();
    chk("R9 request one cycle", {31'b0, req}, 32'h0);
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin if (req) seen++; cyc(); end
      chk("R9 request fires once", seen, 0);
    end
  endtask

  task automatic t_resets();
    sreset(2'b11);
    chk("R3 watchdog reset keeps both errors", status, 32'hFFFC0013);
    sreset(2'b10);
    chk("R2 software reset", status, 32'hFFFC0010);
    pw_err = 1; cyc(); idle();
    wr(0, 1, 1, 16'h0000);
    sreset(2'b11);
    chk("R3 keeps access only, clears dis/clk", status, 32'hFFFC0011);
    sreset(2'b01);
    chk("R2 hardware reset", status, 32'hFFFC0010);
    wr(1, 0, 0, 16'hFFFF);
    ticks(1);
    chk("R8 wrap without timeout mode", status, 32'h00000020);
    sreset(2'b00);
    chk("R2 power-on cause", status, 32'hFFFC0010);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    t_reset();
    t_count();
    t_access();
    t_mode();
    t_overflow();
    t_resets();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule